// File: doc/BRIEF.md
# Reset and Calibration Status Controller

This block sequences the start-up of a data converter's digital core. An active-low reset pin holds the core in a reset state. When the pin is released, the block pulses a strobe that loads the user registers with their default values. It then runs a power-up calibration and raises a calibration-done status pin once that calibration finishes. A soft-reset command repeats the register reload and the calibration without a hardware reset. Standby and shutdown requests move the core into low-power modes, and the status pin keeps its value while the core is in either mode.

The calibration engine is modelled as a counter whose length is set by the `CAL_CYCLES` parameter. The reset pin passes through a two-flop synchroniser. Its assertion takes effect at once, and its release is recognised by detecting a rising edge on the synchronised copy.

The controller is a six-state machine:

- `ST_RESET`: the pin is held low.
- `ST_LOAD`: a single cycle in which the defaults are loaded and the calibration is started.
- `ST_CAL`: the calibration is running.
- `ST_RUN`: normal operation.
- `ST_STBY`: standby mode.
- `ST_SHDN`: shutdown mode.

The transitions are:

- `ST_RESET` to `ST_LOAD` when a rising edge is seen on the synchronised reset.
- Any state other than `ST_RESET` to `ST_LOAD` when `soft_rst` is high.
- `ST_LOAD` to `ST_CAL` unconditionally.
- `ST_CAL` to the mode chosen by the requests when the counter expires.
- Among `ST_RUN`, `ST_STBY` and `ST_SHDN`, the requested mode is followed on each cycle. Shutdown takes priority over standby.
- Any state to `ST_RESET` asynchronously while the pin is low.

Top module: `cal_seq_ctrl`

## Requirements
- R1: While `rst_pin_n` is low, `cal_done_pin`, `cal_busy`, `ld_dflt` and `cal_start` are 0 and `pwr_mode` is 0. These values take effect without waiting for a clock edge.
- R2: After `rst_pin_n` rises between clock edges, `ld_dflt` is high for exactly one cycle, starting at the third rising clock edge after the release.
- R3: `cal_busy` rises in the cycle after the load cycle and stays high for exactly `CAL_CYCLES` cycles, unless a reset interrupts it.
- R4: `cal_done_pin` is low from reset until the first calibration completes. It rises in the same cycle in which `cal_busy` falls at the end of a completed calibration.
- R5: While `pwr_mode` is 1 or 2, `cal_done_pin` keeps the value it had when the mode was entered.
- R6: A `soft_rst` pulse in any non-reset state causes the following, from the next cycle: a one-cycle `ld_dflt` pulse, `cal_done_pin` cleared, and a full new calibration. This also applies when a calibration is already running, which is then restarted.
- R7: Standby or shutdown requests are not honoured while `cal_busy` is high. `pwr_mode` stays 0 and the requested mode is entered in the same cycle in which the calibration completes.
- R8: `pwr_mode` encodes the mode as 0 for active, 1 for standby and 2 for shutdown. `shdn_req` takes priority over `stby_req`, and the mode follows the requests one cycle after they change.
- R9: Asserting `rst_pin_n` low during operation clears `cal_done_pin` and returns `pwr_mode` to 0 before the next clock edge.
- R10: `cal_start` is high exactly in the cycle in which `ld_dflt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin_n | input | 1 | Active-low hardware reset pin, asynchronous |
| soft_rst | input | 1 | Soft-reset command, one-cycle pulse |
| stby_req | input | 1 | Standby mode request, level |
| shdn_req | input | 1 | Shutdown mode request, level |
| ld_dflt | output | 1 | Strobe that loads register defaults |
| cal_start | output | 1 | Calibration start pulse |
| cal_busy | output | 1 | Calibration in progress |
| cal_done_pin | output | 1 | Calibration-done status pin |
| pwr_mode | output | 2 | Current mode: 0 active, 1 standby, 2 shutdown |

## Verification
The following properties are checked on every cycle:

- The reset state holds while the pin is low.
- The load strobe lasts one cycle and is followed by the busy flag.
- The status pin is clear during a load.
- The status pin rises only when the busy flag falls.
- A checker counter confirms the exact busy length.
- The status pin holds in low-power modes.
- No mode change occurs during calibration.
- The mode code stays legal.

The bench scenarios show what the properties cannot. They cover the exact latency of the two-stage synchroniser and edge detector, and a deferred shutdown taking effect in the completion cycle. They also cover a soft reset restarting a running calibration, and an asynchronous clear of a high status pin while the core is in standby, followed by recovery into the still-requested mode.

// File: rtl/cal_seq_pkg.sv
`timescale 1ns/1ps
package cal_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_LOAD  = 3'd1,
        ST_CAL   = 3'd2,
        ST_RUN   = 3'd3,
        ST_STBY  = 3'd4,
        ST_SHDN  = 3'd5
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_ACTIVE = 2'd0,
        MODE_STBY   = 2'd1,
        MODE_SHDN   = 2'd2
    } pwr_mode_t;

endpackage

// File: rtl/rst_sync_edge.sv
`timescale 1ns/1ps
// Reset pin synchroniser: asynchronous assertion, synchronised release,
// plus a one-cycle pulse marking the release on the clock domain.
module rst_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_q,
    output logic release_pulse
);

    logic [STAGES-1:0] chain;
    logic              rst_q_d;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain <= '0;
                else         chain <= 1'b1;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain <= '0;
                else         chain <= {chain[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign rst_q = chain[STAGES-1];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) rst_q_d <= 1'b0;
        else         rst_q_d <= rst_q;
    end

    assign release_pulse = rst_q & ~rst_q_d;

endmodule

// File: rtl/cal_timer.sv
`timescale 1ns/1ps
// Stand-in for the calibration engine: counts CAL_CYCLES cycles after start.
module cal_timer #(
    parameter int CAL_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int CW = $clog2(CAL_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CAL_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= LOAD_VAL;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == '0);

endmodule

// File: rtl/cal_seq_fsm.sv
`timescale 1ns/1ps
module cal_seq_fsm
    import cal_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       release_pulse,
    input  logic       soft_rst,
    input  logic       stby_req,
    input  logic       shdn_req,
    input  logic       timer_done,
    output logic       ld_dflt,
    output logic       cal_start,
    output logic       cal_busy,
    output logic       cal_status,
    output logic [1:0] pwr_mode
);

    seq_state_t state, state_nx;
    logic       status_q;

    function automatic seq_state_t mode_target(input logic stby, input logic shdn);
        if (shdn)      return ST_SHDN;
        else if (stby) return ST_STBY;
        else           return ST_RUN;
    endfunction

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RESET: if (release_pulse) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = soft_rst ? ST_LOAD : ST_CAL;
            ST_CAL: begin
                if (soft_rst)        state_nx = ST_LOAD;
                else if (timer_done) state_nx = mode_target(stby_req, shdn_req);
            end
            ST_RUN, ST_STBY, ST_SHDN: begin
                if (soft_rst) state_nx = ST_LOAD;
                else          state_nx = mode_target(stby_req, shdn_req);
            end
            default: state_nx = ST_RESET;
        endcase
    end

    // state and status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RESET;
            status_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_LOAD)
                status_q <= 1'b0;
            else if (state == ST_CAL && timer_done)
                status_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        ld_dflt   = 1'b0;
        cal_start = 1'b0;
        cal_busy  = 1'b0;
        pwr_mode  = MODE_ACTIVE;
        unique case (state)
            ST_RESET: ;
            ST_LOAD: begin
                ld_dflt   = 1'b1;
                cal_start = 1'b1;
            end
            ST_CAL:  cal_busy = 1'b1;
            ST_RUN:  ;
            ST_STBY: pwr_mode = MODE_STBY;
            ST_SHDN: pwr_mode = MODE_SHDN;
            default: ;
        endcase
    end

    assign cal_status = status_q;

endmodule

// File: rtl/cal_seq_ctrl.sv
`timescale 1ns/1ps
module cal_seq_ctrl #(
    parameter int CAL_CYCLES  = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_pin_n,
    input  logic       soft_rst,
    input  logic       stby_req,
    input  logic       shdn_req,
    output logic       ld_dflt,
    output logic       cal_start,
    output logic       cal_busy,
    output logic       cal_done_pin,
    output logic [1:0] pwr_mode
);

    logic core_rst_n;
    logic rel_pulse;
    logic tmr_done;

    rst_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk           (clk),
        .arst_n        (rst_pin_n),
        .rst_q         (core_rst_n),
        .release_pulse (rel_pulse)
    );

    cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (core_rst_n),
        .start (cal_start),
        .done  (tmr_done)
    );

    cal_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (core_rst_n),
        .release_pulse (rel_pulse),
        .soft_rst      (soft_rst),
        .stby_req      (stby_req),
        .shdn_req      (shdn_req),
        .timer_done    (tmr_done),
        .ld_dflt       (ld_dflt),
        .cal_start     (cal_start),
        .cal_busy      (cal_busy),
        .cal_status    (cal_done_pin),
        .pwr_mode      (pwr_mode)
    );

endmodule

// File: rtl/cal_seq_ctrl_chk.sv
`timescale 1ns/1ps
module cal_seq_ctrl_chk #(
    parameter int CAL_CYCLES = 20
) (
    input logic       clk,
    input logic       rst_pin_n,
    input logic       soft_rst,
    input logic       ld_dflt,
    input logic       cal_start,
    input logic       cal_busy,
    input logic       cal_done_pin,
    input logic [1:0] pwr_mode
);

    localparam int BW = $clog2(CAL_CYCLES + 2) + 1;
    logic [BW-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n)    busy_len <= '0;
        else if (cal_busy) busy_len <= busy_len + 1'b1;
        else               busy_len <= '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_pin_n |-> (!cal_done_pin && !cal_busy && !ld_dflt && !cal_start && pwr_mode == 2'd0)); // R1

    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (ld_dflt && !soft_rst) |=> !ld_dflt); // R2

    AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (ld_dflt && !soft_rst) |=> cal_busy); // R3

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_pin_n)
        ($fell(cal_busy) && !ld_dflt) |-> (busy_len == BW'(CAL_CYCLES))); // R3

    AST_DONE_WITH_BUSY_END: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $rose(cal_done_pin) |-> $fell(cal_busy)); // R4

    AST_STATUS_HOLD_LOWPWR: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (pwr_mode != 2'd0 && $past(pwr_mode) != 2'd0) |-> $stable(cal_done_pin)); // R5

    AST_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_pin_n)
        ld_dflt |-> !cal_done_pin); // R6

    AST_NO_MODE_IN_CAL: assert property (@(posedge clk) disable iff (!rst_pin_n)
        cal_busy |-> (pwr_mode == 2'd0)); // R7

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_pin_n)
        pwr_mode != 2'd3); // R8

    AST_START_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_pin_n)
        cal_start |=> (cal_busy || ld_dflt)); // R10

endmodule

bind cal_seq_ctrl cal_seq_ctrl_chk #(.CAL_CYCLES(CAL_CYCLES)) u_chk (
    .clk          (clk),
    .rst_pin_n    (rst_pin_n),
    .soft_rst     (soft_rst),
    .ld_dflt      (ld_dflt),
    .cal_start    (cal_start),
    .cal_busy     (cal_busy),
    .cal_done_pin (cal_done_pin),
    .pwr_mode     (pwr_mode)
);

// File: tb/cal_seq_ctrl_test.sv
`timescale 1ns/1ps
module cal_seq_ctrl_test;

    localparam int N = 12;
    localparam int EV_LD = 0, EV_CLR = 1, EV_DONE = 2, EV_BEND = 3, EV_MODE = 4;

    typedef struct {
        int    kind;
        int    val;
        int    cyc;
        string req;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst_pin_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       stby_req = 1'b0;
    logic       shdn_req = 1'b0;
    logic       ld_dflt, cal_start, cal_busy, cal_done_pin;
    logic [1:0] pwr_mode;

    int  cyc = 0;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  mon_en = 1'b0;
    bit  finished = 1'b0;
    ev_t expq[$];

    logic       p_ld, p_st, p_busy;
    logic [1:0] p_mode;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    cal_seq_ctrl #(.CAL_CYCLES(N)) uut (
        .clk          (clk),
        .rst_pin_n    (rst_pin_n),
        .soft_rst     (soft_rst),
        .stby_req     (stby_req),
        .shdn_req     (shdn_req),
        .ld_dflt      (ld_dflt),
        .cal_start    (cal_start),
        .cal_busy     (cal_busy),
        .cal_done_pin (cal_done_pin),
        .pwr_mode     (pwr_mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input int val, input int at, input string req);
        ev_t e;
        e.kind = kind; e.val = val; e.cyc = at; e.req = req;
        expq.push_back(e);
    endtask

    task automatic observe(input int kind, input int val);
        ev_t e;
        if (expq.size() == 0) begin
            check(1'b0, "unexpected event", kind, -1);
        end else begin
            e = expq.pop_front();
            check(e.kind == kind, e.req, kind, e.kind);
            check(e.val == val, e.req, val, e.val);
            check(e.cyc == cyc, e.req, cyc, e.cyc);
        end
    endtask

    // monitor: detects output events and compares against the queue
    always @(negedge clk) begin
        if (mon_en) begin
            if (ld_dflt && !p_ld)        observe(EV_LD, int'(cal_start));
            if (!cal_done_pin && p_st)   observe(EV_CLR, 0);
            if (cal_done_pin && !p_st)   observe(EV_DONE, 0);
            if (!cal_busy && p_busy)     observe(EV_BEND, 0);
            if (pwr_mode != p_mode)      observe(EV_MODE, int'(pwr_mode));
        end
        p_ld = ld_dflt; p_st = cal_done_pin; p_busy = cal_busy; p_mode = pwr_mode;
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic drain();
        while (expq.size() != 0) step();
        repeat (3) step();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int c;
        repeat (4) step();
        // R1: reset state
        check(!cal_done_pin && !cal_busy && !ld_dflt && !cal_start && pwr_mode == 2'd0,
              "R1 reset outputs", {cal_done_pin, cal_busy, ld_dflt, cal_start, pwr_mode}, 0);
        mon_en = 1'b1;

        // R2/R3/R4/R10: release and power-up calibration
        c = cyc; rst_pin_n = 1'b1;
        push(EV_LD, 1, c + 3, "R2 R10 load strobe after release");
        push(EV_DONE, 0, c + 4 + N, "R4 status rises at end of cal");
        push(EV_BEND, 0, c + 4 + N, "R3 busy length");
        repeat (6) step();
        check(cal_done_pin == 1'b0, "R4 status low during first cal", int'(cal_done_pin), 0);
        drain();

        // R8/R5: low-power modes
        c = cyc; stby_req = 1'b1;
        push(EV_MODE, 1, c + 1, "R8 standby entry");
        repeat (3) step();
        check(cal_done_pin == 1'b1, "R5 status held in standby", int'(cal_done_pin), 1);
        c = cyc; shdn_req = 1'b1;
        push(EV_MODE, 2, c + 1, "R8 shutdown priority");
        repeat (3) step();
        check(cal_done_pin == 1'b1, "R5 status held in shutdown", int'(cal_done_pin), 1);
        c = cyc; shdn_req = 1'b0;
        push(EV_MODE, 1, c + 1, "R8 back to standby");
        drain();
        c = cyc; stby_req = 1'b0;
        push(EV_MODE, 0, c + 1, "R8 back to active");
        drain();

        // R6/R7: soft reset while in shutdown, shutdown deferred past cal
        c = cyc; shdn_req = 1'b1;
        push(EV_MODE, 2, c + 1, "R8 shutdown entry");
        drain();
        c = cyc; soft_rst = 1'b1;
        push(EV_LD, 1, c + 1, "R6 soft reset load");
        push(EV_CLR, 0, c + 1, "R6 soft reset clears status");
        push(EV_MODE, 0, c + 1, "R6 leave shutdown on soft reset");
        push(EV_DONE, 0, c + 2 + N, "R6 new cal completes");
        push(EV_BEND, 0, c + 2 + N, "R6 new cal length");
        push(EV_MODE, 2, c + 2 + N, "R7 deferred shutdown entry");
        step(); soft_rst = 1'b0;
        repeat (4) step();
        check(pwr_mode == 2'd0 && cal_busy, "R7 no mode change during cal", int'(pwr_mode), 0);
        drain();
        c = cyc; shdn_req = 1'b0;
        push(EV_MODE, 0, c + 1, "R8 shutdown exit");
        drain();

        // R6: soft reset restarting a running calibration
        c = cyc; soft_rst = 1'b1;
        push(EV_LD, 1, c + 1, "R6 soft reset load");
        push(EV_CLR, 0, c + 1, "R6 soft reset clears status");
        step(); soft_rst = 1'b0;
        repeat (4) step();
        c = cyc; soft_rst = 1'b1;
        push(EV_LD, 1, c + 1, "R6 restart during cal");
        push(EV_BEND, 0, c + 1, "R6 busy drops on restart");
        push(EV_DONE, 0, c + 2 + N, "R6 restarted cal completes");
        push(EV_BEND, 0, c + 2 + N, "R6 restarted cal length");
        step(); soft_rst = 1'b0;
        drain();

        // R9: hardware reset in standby, then recovery into requested mode
        c = cyc; stby_req = 1'b1;
        push(EV_MODE, 1, c + 1, "R8 standby entry");
        drain();
        c = cyc; rst_pin_n = 1'b0;
        push(EV_CLR, 0, c + 1, "R9 async clear of status");
        push(EV_MODE, 0, c + 1, "R9 mode cleared by reset");
        #1;
        check(!cal_done_pin && pwr_mode == 2'd0, "R9 cleared before next edge",
              {cal_done_pin, pwr_mode}, 0);
        drain();
        check(!ld_dflt && !cal_busy && !cal_start, "R1 outputs held in reset",
              {ld_dflt, cal_busy, cal_start}, 0);
        c = cyc; rst_pin_n = 1'b1;
        push(EV_LD, 1, c + 3, "R2 R10 load strobe after release");
        push(EV_DONE, 0, c + 4 + N, "R4 status after recal");
        push(EV_BEND, 0, c + 4 + N, "R3 busy length");
        push(EV_MODE, 1, c + 4 + N, "R7 deferred standby after reset");
        drain();

        check(expq.size() == 0, "all expected events seen", expq.size(), 0);
        summary();
    end

endmodule